// File: doc/BRIEF.md
# CPU Clock Source Switcher

This block picks the clock that drives the CPU from three sources: an internal RC oscillator, a crystal oscillator and a clock fed in on an external pin. Software drives it through four byte-wide registers. A move onto the main (crystal or pin) clock is taken only when that path is powered, routed and ready. A move back to the RC clock is taken only when the RC oscillator is running. A request that fails its precondition is dropped, and a status bit shows the committed source. An oscillator cannot be switched off while it feeds the CPU, and the choice between crystal and pin cannot change while the main clock is in use.

Setting the amplitude-control bit holds the CPU clock off for a settling window. The window is counted in pin-clock rising edges in pin mode and in controller-clock cycles in crystal mode. The STOP sequence first asks peripherals to halt. Once they report idle, it gates the CPU clock until a wake event arrives. The output clock comes from a three-way glitch-free multiplexer. Each branch closes on its own falling edge and opens only after a two-flop synchroniser in its own clock domain has seen that every other branch is closed. The oscillators are modelled as free-running clock inputs plus a crystal-ready flag.

Registers: address 0 is source config (bit0 pin enable, bit1 pin-mode select, 1 = external pin and 0 = crystal, bit2 amplitude control). Address 1 holds the oscillator-off bits (bit0 main off, bit1 RC off). Address 2 is CPU select (write bit0 = 1 requests the main clock and 0 requests RC; read bit1 = 1 while the main clock is committed). Address 3 is power (write bit0 = 1 starts the STOP sequence; read bit0 halt request, bit1 stopped).

Top module: `cpu_clk_switch`

## Requirements
- R1: After reset the CPU runs from RC: address 0 reads 0x00, address 1 reads 0x01 (main off), address 2 reads 0x00, and hold, halt and stop outputs are low.
- R2: A request for the main clock in crystal mode is taken only if main-off is 0, pin enable is 1 and xt_ready is 1. Otherwise address 2 bit1 stays 0.
- R3: A request for the main clock in pin mode is taken when main-off is 0 and pin enable is 1, whatever the level of xt_ready.
- R4: A request to return to RC is ignored while RC-off is 1, and it is taken once RC-off is 0.
- R5: Writing main-off = 1 while the main clock is committed is rejected, and the bit reads 0.
- R6: Writing RC-off = 1 while RC is committed is rejected, and the bit reads 0.
- R7: While the main clock is committed, writes to pin enable and pin-mode select have no effect.
- R8: A 0-to-1 write of the amplitude bit in crystal mode raises cpu_hold for exactly HOLD_XT_CYCLES controller cycles, and cpu_clk has no edges inside the window.
- R9: A 0-to-1 write of the amplitude bit in pin mode raises cpu_hold for HOLD_EXT_EDGES rising edges of ext_clk, within one edge.
- R10: While cpu_hold is high, source-select writes and STOP commands are ignored.
- R11: A STOP command raises periph_halt at once. stop_mode rises only after periph_idle is high, and wake returns both to low.
- R12: cpu_clk toggles at the rate of the committed source and never shows a pulse shorter than half the fastest source period.
- R13: rc_en equals NOT RC-off. xt_en is high only with main-off 0, pin enable 1 and crystal mode. ext_pin_en is high only with main-off 0, pin enable 1 and pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_clk | input | 1 | Internal RC oscillator clock |
| xt_clk | input | 1 | Crystal oscillator clock |
| ext_clk | input | 1 | External pin clock |
| xt_ready | input | 1 | Crystal stabilisation time has elapsed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| periph_idle | input | 1 | Peripherals have halted |
| wake | input | 1 | Wake event that ends STOP |
| cpu_clk | output | 1 | Selected CPU clock |
| cpu_hold | output | 1 | Amplitude settling hold active |
| periph_halt | output | 1 | Request for peripherals to halt |
| stop_mode | output | 1 | CPU clock stopped for STOP |
| rc_en | output | 1 | RC oscillator enable |
| xt_en | output | 1 | Crystal oscillator enable |
| ext_pin_en | output | 1 | External clock input enable |

## Verification
The bench makes each switch precondition fail on its own (main off, crystal not ready, RC off). A design that checked the wrong flag would report the main source as committed, or strand the CPU on a stopped oscillator. It tries to power down the live oscillator and to change the pin mode under a running main clock, where a faulty guard shows up in the read-back value. It measures both settling windows. Here an off-by-one counter or the wrong tick source gives a window of the wrong length, or cpu_clk edges inside it. It also checks the STOP handshake ordering, and it tracks the shortest cpu_clk pulse across every changeover, so a mux that opens a branch before the others close gives a runt pulse.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
    localparam int DW   = 8;
    localparam int AW   = 2;
    localparam int NSRC = 3;

    localparam logic [AW-1:0] ADR_SRC = 2'd0;
    localparam logic [AW-1:0] ADR_OFF = 2'd1;
    localparam logic [AW-1:0] ADR_SEL = 2'd2;
    localparam logic [AW-1:0] ADR_PWR = 2'd3;

    localparam int SRC_RC  = 0;
    localparam int SRC_XT  = 1;
    localparam int SRC_EXT = 2;

    typedef enum logic [1:0] {
        PW_RUN     = 2'd0,
        PW_QUIESCE = 2'd1,
        PW_STOP    = 2'd2
    } pwr_e;

    typedef struct packed {
        logic pin_en;
        logic ext_mode;
        logic amp;
        logic main_off;
        logic rc_off;
        logic on_main;
        pwr_e pwr;
    } ctl_s;
endpackage

// File: rtl/clksw_edge_sync.sv
module clksw_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[SW-2] & ~sh_q[SW-1];
endmodule

// File: rtl/clksw_hold_timer.sv
module clksw_hold_timer #(
    parameter int XT_CYCLES = 200,
    parameter int EXT_EDGES = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic use_ext,
    input  logic ext_tick,
    output logic active
);
    localparam int LIM = (XT_CYCLES > EXT_EDGES) ? XT_CYCLES : EXT_EDGES;
    localparam int CW  = (LIM < 2) ? 1 : $clog2(LIM + 1);

    typedef struct packed {
        logic          active;
        logic          use_ext;
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s d, q;
    logic tick;

    always_comb begin
        d    = q;
        tick = q.use_ext ? ext_tick : 1'b1;
        if (!q.active) begin
            if (start) begin
                d.active  = 1'b1;
                d.use_ext = use_ext;
                d.cnt     = use_ext ? CW'(EXT_EDGES - 1) : CW'(XT_CYCLES - 1);
            end
        end else if (tick) begin
            if (q.cnt == '0) d.active = 1'b0;
            else             d.cnt    = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.active;
endmodule

// File: rtl/clksw_gfmux.sv
module clksw_gfmux #(
    parameter int N = 3
) (
    input  logic         rst_n,
    input  logic [N-1:0] src_clk,
    input  logic [N-1:0] sel,
    input  logic         allow,
    output logic         clk_out
);
    logic [N-1:0] gate;

    for (genvar gi = 0; gi < N; gi++) begin : g_branch
        logic others;
        logic req;
        logic s1_q, s2_q, g_q;

        assign others = |(gate & ~(N'(1) << gi));
        assign req    = sel[gi] & allow & ~others;

        always_ff @(posedge src_clk[gi] or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= req;
                s2_q <= s1_q;
            end
        end

        always_ff @(negedge src_clk[gi] or negedge rst_n) begin
            if (!rst_n) g_q <= 1'b0;
            else        g_q <= s2_q;
        end

        assign gate[gi] = g_q;
    end

    assign clk_out = |(src_clk & gate);
endmodule

// File: rtl/cpu_clk_switch.sv
module cpu_clk_switch
    import clksw_pkg::*;
#(
    parameter int HOLD_XT_CYCLES = 200,
    parameter int HOLD_EXT_EDGES = 160,
    parameter int SYNC_STAGES    = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rc_clk,
    input  logic          xt_clk,
    input  logic          ext_clk,
    input  logic          xt_ready,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          periph_idle,
    input  logic          wake,
    output logic          cpu_clk,
    output logic          cpu_hold,
    output logic          periph_halt,
    output logic          stop_mode,
    output logic          rc_en,
    output logic          xt_en,
    output logic          ext_pin_en
);
    ctl_s d, q;

    logic            hold;
    logic            ext_rise;
    logic            start_hold;
    logic            main_ok;
    logic            on_main, main_off, rc_off, pin_en, ext_mode;
    logic [NSRC-1:0] sel_d, sel_q;
    logic            allow_d, allow_q;

    // Control next-state: register writes, switch guards, STOP sequencing
    always_comb begin
        d          = q;
        start_hold = 1'b0;
        main_ok    = !q.main_off && q.pin_en && (q.ext_mode || xt_ready);

        if (wr_en && q.pwr == PW_RUN) begin
            unique case (wr_addr)
                ADR_SRC: begin
                    if (!q.on_main) begin
                        d.pin_en   = wr_data[0];
                        d.ext_mode = wr_data[1];
                    end
                    if (!hold) begin
                        d.amp      = wr_data[2];
                        start_hold = wr_data[2] && !q.amp;
                    end
                end
                ADR_OFF: begin
                    if (!(wr_data[0] && q.on_main))  d.main_off = wr_data[0];
                    if (!(wr_data[1] && !q.on_main)) d.rc_off   = wr_data[1];
                end
                ADR_SEL: begin
                    if (!hold) begin
                        if (wr_data[0] && !q.on_main && main_ok)   d.on_main = 1'b1;
                        if (!wr_data[0] && q.on_main && !q.rc_off) d.on_main = 1'b0;
                    end
                end
                ADR_PWR: begin
                    if (!hold && wr_data[0]) d.pwr = PW_QUIESCE;
                end
                default: ;
            endcase
        end

        unique case (q.pwr)
            PW_QUIESCE: if (periph_idle) d.pwr = PW_STOP;
            PW_STOP:    if (wake)        d.pwr = PW_RUN;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.main_off <= 1'b1;
            q.pwr      <= PW_RUN;
        end else begin
            q <= d;
        end
    end

    // Registered mux controls so the cross-domain inputs never glitch
    always_comb begin
        sel_d            = '0;
        sel_d[SRC_RC]    = !q.on_main;
        sel_d[SRC_XT]    = q.on_main && !q.ext_mode;
        sel_d[SRC_EXT]   = q.on_main && q.ext_mode;
        allow_d          = !hold && (q.pwr != PW_STOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            allow_q <= 1'b0;
        end else begin
            sel_q   <= sel_d;
            allow_q <= allow_d;
        end
    end

    clksw_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_ext_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_clk),
        .rise     (ext_rise)
    );

    clksw_hold_timer #(
        .XT_CYCLES (HOLD_XT_CYCLES),
        .EXT_EDGES (HOLD_EXT_EDGES)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_hold),
        .use_ext  (d.ext_mode),
        .ext_tick (ext_rise),
        .active   (hold)
    );

    clksw_gfmux #(
        .N (NSRC)
    ) u_mux (
        .rst_n   (rst_n),
        .src_clk ({ext_clk, xt_clk, rc_clk}),
        .sel     (sel_q),
        .allow   (allow_q),
        .clk_out (cpu_clk)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_SRC: rd_data[2:0] = {q.amp, q.ext_mode, q.pin_en};
            ADR_OFF: rd_data[1:0] = {q.rc_off, q.main_off};
            ADR_SEL: rd_data[1]   = q.on_main;
            ADR_PWR: rd_data[1:0] = {q.pwr == PW_STOP, q.pwr != PW_RUN};
            default: ;
        endcase
    end

    assign on_main     = q.on_main;
    assign main_off    = q.main_off;
    assign rc_off      = q.rc_off;
    assign pin_en      = q.pin_en;
    assign ext_mode    = q.ext_mode;
    assign cpu_hold    = hold;
    assign periph_halt = (q.pwr != PW_RUN);
    assign stop_mode   = (q.pwr == PW_STOP);
    assign rc_en       = !q.rc_off;
    assign xt_en       = !q.main_off && q.pin_en && !q.ext_mode;
    assign ext_pin_en  = !q.main_off && q.pin_en && q.ext_mode;
endmodule

// File: rtl/cpu_clk_switch_chk.sv
module cpu_clk_switch_chk (
    input logic clk,
    input logic rst_n,
    input logic on_main,
    input logic main_off,
    input logic rc_off,
    input logic pin_en,
    input logic ext_mode,
    input logic xt_ready,
    input logic hold,
    input logic stop_mode,
    input logic periph_halt,
    input logic periph_idle
);
    AST_MAIN_SWITCH_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_main) |-> $past(pin_en && !main_off && (ext_mode || xt_ready))); // R2
    AST_RC_RETURN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_main) |-> $past(!rc_off)); // R4
    AST_MAIN_LIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        on_main |-> !main_off); // R5
    AST_RC_LIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !on_main |-> !rc_off); // R6
    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (on_main && $past(on_main)) |-> ($stable(pin_en) && $stable(ext_mode))); // R7
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> $stable(on_main)); // R10
    AST_STOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_mode) |-> $past(periph_halt && periph_idle)); // R11
    AST_STOP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        stop_mode |-> periph_halt); // R11
endmodule

bind cpu_clk_switch cpu_clk_switch_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_main     (on_main),
    .main_off    (main_off),
    .rc_off      (rc_off),
    .pin_en      (pin_en),
    .ext_mode    (ext_mode),
    .xt_ready    (xt_ready),
    .hold        (hold),
    .stop_mode   (stop_mode),
    .periph_halt (periph_halt),
    .periph_idle (periph_idle)
);

// File: tb/cpu_clk_switch_test.sv
`timescale 1ns/1ps
module cpu_clk_switch_test;
    localparam int XT_HOLD  = 200;
    localparam int EXT_HOLD = 160;

    logic       clk = 0, rst_n = 0;
    logic       rc_clk = 0, xt_clk = 0, ext_clk = 0;
    logic       xt_ready = 0, wr_en = 0, periph_idle = 0, wake = 0;
    logic [1:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       cpu_clk, cpu_hold, periph_halt, stop_mode, rc_en, xt_en, ext_pin_en;

    int total = 0, bad = 0;
    int cpu_edges = 0, ext_in_hold = 0;
    realtime t_rise = 0, t_fall = 0, min_hi = 1.0e9, min_lo = 1.0e9;
    bit seen_rise = 0, seen_fall = 0;

    always #10 clk     = ~clk;
    always #15 rc_clk  = ~rc_clk;
    always #20 xt_clk  = ~xt_clk;
    always #50 ext_clk = ~ext_clk;

    cpu_clk_switch #(.HOLD_XT_CYCLES(XT_HOLD), .HOLD_EXT_EDGES(EXT_HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .rc_clk(rc_clk), .xt_clk(xt_clk), .ext_clk(ext_clk),
        .xt_ready(xt_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .periph_idle(periph_idle), .wake(wake),
        .cpu_clk(cpu_clk), .cpu_hold(cpu_hold), .periph_halt(periph_halt),
        .stop_mode(stop_mode), .rc_en(rc_en), .xt_en(xt_en), .ext_pin_en(ext_pin_en)
    );

    always @(posedge cpu_clk) begin
        cpu_edges++;
        if (seen_fall && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime; seen_rise = 1;
    end
    always @(negedge cpu_clk) begin
        if (seen_rise && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        t_fall = $realtime; seen_fall = 1;
    end
    always @(posedge ext_clk) if (cpu_hold) ext_in_hold++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); rd_addr = a; #1; v = rd_data;
    endtask

    task automatic count_rate(output int n);
        int start;
        repeat (20) @(negedge clk);
        start = cpu_edges;
        repeat (100) @(negedge clk);
        n = cpu_edges - start;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd0, v); check(v == 8'h00, "R1 src", v, 0);
        rd(2'd1, v); check(v == 8'h01, "R1 off", v, 1);
        rd(2'd2, v); check(v == 8'h00, "R1 sel", v, 0);
        check(!cpu_hold && !periph_halt && !stop_mode, "R1 outputs", {cpu_hold, periph_halt, stop_mode}, 0);
        check(rc_en && !xt_en && !ext_pin_en, "R13 reset enables", {rc_en, xt_en, ext_pin_en}, 4);
    endtask

    task automatic t_crystal_switch;
        logic [7:0] v; int n;
        wr(2'd2, 8'h01); rd(2'd2, v); check(v[1] == 0, "R2 main off blocks", v[1], 0);
        wr(2'd1, 8'h00); wr(2'd0, 8'h01);
        check(xt_en && !ext_pin_en, "R13 xt enable", {xt_en, ext_pin_en}, 2);
        xt_ready = 0;
        wr(2'd2, 8'h01); rd(2'd2, v); check(v[1] == 0, "R2 not ready blocks", v[1], 0);
        xt_ready = 1;
        wr(2'd2, 8'h01); rd(2'd2, v); check(v[1] == 1, "R2 switch taken", v[1], 1);
        count_rate(n); check(n >= 48 && n <= 52, "R12 crystal rate", n, 50);
    endtask

    task automatic t_stop_guards;
        logic [7:0] v; int n;
        wr(2'd1, 8'h01); rd(2'd1, v); check(v == 8'h00, "R5 live main stop", v, 0);
        wr(2'd1, 8'h02); rd(2'd1, v); check(v == 8'h02, "R13 rc off accepted", v, 2);
        check(!rc_en, "R13 rc_en low", rc_en, 0);
        wr(2'd0, 8'h03); rd(2'd0, v); check(v == 8'h01, "R7 mode locked", v, 1);
        wr(2'd2, 8'h00); rd(2'd2, v); check(v[1] == 1, "R4 rc off blocks return", v[1], 1);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00); rd(2'd2, v); check(v[1] == 0, "R4 return taken", v[1], 0);
        count_rate(n); check(n >= 65 && n <= 69, "R12 rc rate", n, 67);
        wr(2'd1, 8'h02); rd(2'd1, v); check(v == 8'h00, "R6 live rc stop", v, 0);
    endtask

    task automatic t_ext_switch;
        logic [7:0] v; int n;
        wr(2'd0, 8'h03); xt_ready = 0;
        wr(2'd2, 8'h01); rd(2'd2, v); check(v[1] == 1, "R3 pin switch no ready", v[1], 1);
        check(ext_pin_en && !xt_en, "R13 pin enable", {ext_pin_en, xt_en}, 2);
        count_rate(n); check(n >= 19 && n <= 21, "R12 pin rate", n, 20);
    endtask

    task automatic t_hold_ext;
        logic [7:0] v; int snap;
        ext_in_hold = 0;
        wr(2'd0, 8'h07);
        check(cpu_hold == 1, "R9 hold starts", cpu_hold, 1);
        repeat (10) @(negedge clk);
        snap = cpu_edges;
        wr(2'd2, 8'h00); rd(2'd2, v); check(v[1] == 1, "R10 switch ignored", v[1], 1);
        wr(2'd3, 8'h01); check(!periph_halt, "R10 stop ignored", periph_halt, 0);
        while (cpu_hold) @(negedge clk);
        check(cpu_edges == snap, "R9 clock gated", cpu_edges - snap, 0);
        check(ext_in_hold >= EXT_HOLD - 1 && ext_in_hold <= EXT_HOLD + 1, "R9 edge count", ext_in_hold, EXT_HOLD);
    endtask

    task automatic t_hold_xt;
        logic [7:0] v; int n, snap;
        wr(2'd2, 8'h00); rd(2'd2, v); check(v[1] == 0, "R4 back to rc", v[1], 0);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h05);
        n = 0;
        repeat (10) begin
            if (cpu_hold) n++;
            @(negedge clk);
        end
        snap = cpu_edges;
        while (cpu_hold) begin n++; @(negedge clk); end
        check(n == XT_HOLD, "R8 hold length", n, XT_HOLD);
        check(cpu_edges == snap, "R8 clock gated", cpu_edges - snap, 0);
        count_rate(n); check(n >= 65 && n <= 69, "R8 clock resumes", n, 67);
    endtask

    task automatic t_stop_mode;
        logic [7:0] v; int snap;
        wr(2'd3, 8'h01);
        check(periph_halt && !stop_mode, "R11 halt first", {periph_halt, stop_mode}, 2);
        repeat (5) @(negedge clk);
        check(!stop_mode, "R11 waits idle", stop_mode, 0);
        periph_idle = 1;
        @(negedge clk);
        check(stop_mode == 1, "R11 stopped", stop_mode, 1);
        rd(2'd3, v); check(v == 8'h03, "R11 power read", v, 3);
        repeat (10) @(negedge clk);
        snap = cpu_edges;
        repeat (20) @(negedge clk);
        check(cpu_edges == snap, "R11 clock off", cpu_edges - snap, 0);
        wake = 1; @(negedge clk); wake = 0; periph_idle = 0;
        check(!stop_mode && !periph_halt, "R11 wake", {stop_mode, periph_halt}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset();
        t_crystal_switch();
        t_stop_guards();
        t_ext_switch();
        t_hold_ext();
        t_hold_xt();
        t_stop_mode();
        check(min_hi >= 14.9, "R12 no short high", int'(min_hi), 15);
        check(min_lo >= 14.9, "R12 no short low", int'(min_lo), 15);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule